// File: doc/BRIEF.md
# Serial-Bus Receive Packet Acceptance Filter

This block decides which of several receive buffers should take each incoming packet on an IEEE-1394-style serial bus link. A packet decoder ahead of it presents a header, one cycle at a time, with a strobe. The header carries the packet class (PHY, self-ID, asynchronous or isochronous), the 10-bit destination bus/node ID, the 48-bit destination offset and the isochronous channel. A separate input says whether the bus is in its self-ID phase. One cycle after the strobe the block returns a registered per-buffer accept vector and an accept-valid pulse. Any number of buffers may accept the same packet.

Each buffer has two configuration words on a simple register port with a byte address. The filter word holds the PHY, self-ID, broadcast and receive-all enables and five address-space enables. The stream word marks the buffer as isochronous and holds its 6-bit channel. Buffer n has its filter word at 0x354 + 0x14*n and its stream word at 0x358 + 0x14*n. Buffer 0 is the debug buffer and comes out of reset taking PHY, self-ID and broadcast traffic. Packet storage, the PHY interface and CRC checking are handled elsewhere.

Top module: `rx_accept_filter`

## Requirements
- R1: After reset, the filter word of buffer 0 reads 0x780 and the filter word of each other buffer reads 0x080. Every stream word reads 0x000.
- R2: Filter-word bits 31:11 and 1:0 read as zero, and so do stream-word bits 31:9 and 7:6. Writes to those bits have no effect. An address that is neither a filter word nor a stream word reads zero, and a write to it changes nothing.
- R3: A PHY packet (class code 0) is accepted by exactly those buffers whose filter bit 10 is set.
- R4: A self-ID packet (class code 1) is accepted by buffers whose filter bit 9 is set, and only while selfid_phase is high. Outside the phase, no buffer accepts it.
- R5: An asynchronous packet (class code 2) whose destination ID is 0x3FF is accepted by any non-isochronous buffer whose filter bit 8 (broadcast) is set.
- R6: A non-isochronous buffer whose filter bit 7 (receive-all) is set accepts every asynchronous packet, whatever its offset and destination ID. This holds even when all of its space enables are clear.
- R7: Filter bits 6, 5, 4, 3 and 2 enable, in that order, these offset spaces: lower initial memory [0, 0x7FFF_FFFF_FFFF], upper initial memory [0x8000_0000_0000, 0xFFFF_DFFF_FFFF], private [0xFFFF_E000_0000, 0xFFFF_EFFF_FFFF], CSR core [0xFFFF_F000_0000, 0xFFFF_F000_01FF] and serial-bus [0xFFFF_F000_0200, 0xFFFF_F000_03FF]. An asynchronous packet is accepted if its offset falls in any enabled space.
- R8: Stream-word bit 8 marks a buffer as isochronous, and bits 5:0 hold its channel. An isochronous buffer accepts no asynchronous packet, whatever its broadcast, receive-all and space bits say. It accepts an isochronous packet (class code 3) only when the packet's channel equals its channel. A buffer that is not isochronous accepts no isochronous packet.
- R9: acc_valid is high exactly in the cycle after a cycle with hdr_valid high, and acc_vec holds that header's verdict. acc_vec is zero whenever acc_valid is low. Headers may come on consecutive cycles, and several accept bits may be set at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte address, used for both read and write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, combinational from cfg_addr |
| hdr_valid | input | 1 | Header strobe |
| hdr_kind | input | 2 | Packet class: 0 PHY, 1 self-ID, 2 asynchronous, 3 isochronous |
| hdr_dest_id | input | 10 | Destination bus/node ID |
| hdr_offset | input | 48 | Destination offset |
| hdr_channel | input | 6 | Isochronous channel |
| selfid_phase | input | 1 | High while the bus is in its self-ID phase |
| acc_valid | output | 1 | Accept-vector valid pulse |
| acc_vec | output | 8 | One accept bit per buffer |

## Verification
A wrong configuration bit in this block shows up in two places. It shows on cfg_rdata as soon as the word is read. It also shows in acc_vec exactly one cycle after the first header whose class or offset depends on that bit. A wrong space decode or a wrong isochronous gate shows as one stray or missing accept bit, so the bench places offsets on both sides of every space edge. It also sends every class to buffers of both modes. A timing slip in the output register shows as acc_valid out of step with the strobe, or as stale bits during idle cycles. The scoreboard and the pulse-timing properties catch these on the very next cycle.

// File: rtl/rxf_pkg.sv
// Package: shared packet-class encoding, field positions and space bounds
// for the receive acceptance filter.
// Assumes 48-bit destination offsets.
package rxf_pkg;

    typedef enum logic [1:0] {
        PK_PHY    = 2'd0,
        PK_SELFID = 2'd1,
        PK_ASYNC  = 2'd2,
        PK_ISO    = 2'd3
    } pkt_kind_e;

    // Filter-word field positions
    localparam int F_PHY    = 10;
    localparam int F_SELFID = 9;
    localparam int F_BCAST  = 8;
    localparam int F_ALL    = 7;
    localparam int F_SPHI   = 6;   // space enables occupy 6 down to 2
    localparam int F_SPLO   = 2;
    localparam int NSPACE   = F_SPHI - F_SPLO + 1;

    // Stream-word field positions
    localparam int S_ISO    = 8;

    // Offset-space bounds (inclusive)
    localparam logic [47:0] LO_INIT_MAX  = 48'h7FFF_FFFF_FFFF;
    localparam logic [47:0] HI_INIT_MAX  = 48'hFFFF_DFFF_FFFF;
    localparam logic [47:0] PRIV_MIN     = 48'hFFFF_E000_0000;
    localparam logic [47:0] PRIV_MAX     = 48'hFFFF_EFFF_FFFF;
    localparam logic [47:0] CSR_MIN      = 48'hFFFF_F000_0000;
    localparam logic [47:0] CSR_MAX      = 48'hFFFF_F000_01FF;
    localparam logic [47:0] SBUS_MIN     = 48'hFFFF_F000_0200;
    localparam logic [47:0] SBUS_MAX     = 48'hFFFF_F000_03FF;

endpackage

// File: rtl/rxf_space_decode.sv
// Module: classifies a destination offset into the five offset spaces.
// hit[4]=lower initial, [3]=upper initial, [2]=private, [1]=CSR core,
// [0]=serial-bus, which matches filter bits 6..2.
// Assumes disjoint spaces, so at most one hit bit is set.
module rxf_space_decode
    import rxf_pkg::*;
(
    input  logic [47:0]       offset,
    output logic [NSPACE-1:0] hit
);

    // Compare the offset against each space's inclusive bounds
    always_comb begin
        hit[4] = (offset <= LO_INIT_MAX);
        hit[3] = (offset >  LO_INIT_MAX) && (offset <= HI_INIT_MAX);
        hit[2] = (offset >= PRIV_MIN)    && (offset <= PRIV_MAX);
        hit[1] = (offset >= CSR_MIN)     && (offset <= CSR_MAX);
        hit[0] = (offset >= SBUS_MIN)    && (offset <= SBUS_MAX);
    end

    // Space bounds must never overlap
    always_comb begin
        // R7
        spaces_disjoint_chk: assert ($onehot0(hit));
    end

endmodule

// File: rtl/rxf_cfg_slot.sv
// Module: the two configuration words of one receive buffer.
// The filter word lives at A_ADDR and the stream word at B_ADDR.
// Only defined bits are stored; everything else reads zero.
// Assumes DW >= 11 and CHW <= 8.
module rxf_cfg_slot
    import rxf_pkg::*;
#(
    parameter int AW     = 12,
    parameter int DW     = 32,
    parameter int CHW    = 6,
    parameter int A_ADDR = 'h354,
    parameter int B_ADDR = 'h358,
    parameter logic [DW-1:0] A_RST = 'h080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              phy_en,
    output logic              selfid_en,
    output logic              bcast_en,
    output logic              all_en,
    output logic [NSPACE-1:0] space_en,
    output logic              iso_mode,
    output logic [CHW-1:0]    chan
);

    localparam int FW = F_PHY - F_SPLO + 1;

    logic [FW-1:0]  filt_q;
    logic           iso_q;
    logic [CHW-1:0] chan_q;
    logic           hit_a, hit_b;

    assign hit_a = (addr == AW'(A_ADDR));
    assign hit_b = (addr == AW'(B_ADDR));

    // Hold the filter word; the reset value comes from A_RST
    always_ff @(posedge clk) begin
        if (!rst_n)              filt_q <= A_RST[F_PHY:F_SPLO];
        else if (we && hit_a)    filt_q <= wdata[F_PHY:F_SPLO];
    end

    // Hold the stream word (isochronous flag and channel)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iso_q  <= 1'b0;
            chan_q <= '0;
        end else if (we && hit_b) begin
            iso_q  <= wdata[S_ISO];
            chan_q <= wdata[CHW-1:0];
        end
    end

    // Read mux; unselected slots drive zero so the top can OR them
    always_comb begin
        rdata = '0;
        if (hit_a) rdata[F_PHY:F_SPLO] = filt_q;
        if (hit_b) begin
            rdata[S_ISO]   = iso_q;
            rdata[CHW-1:0] = chan_q;
        end
    end

    assign phy_en    = filt_q[F_PHY    - F_SPLO];
    assign selfid_en = filt_q[F_SELFID - F_SPLO];
    assign bcast_en  = filt_q[F_BCAST  - F_SPLO];
    assign all_en    = filt_q[F_ALL    - F_SPLO];
    assign space_en  = filt_q[F_SPHI - F_SPLO:0];
    assign iso_mode  = iso_q;
    assign chan      = chan_q;

    // R2: a write aimed at another address leaves this slot unchanged
    // R2
    foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !hit_a && !hit_b) |=> ($stable(filt_q) && $stable(iso_q) && $stable(chan_q)));

endmodule

// File: rtl/rxf_buf_match.sv
// Module: the combinational accept decision for one buffer.
// Assumes the offset has already been classified into space hits.
module rxf_buf_match
    import rxf_pkg::*;
#(
    parameter int IDW = 10,
    parameter int CHW = 6
) (
    input  pkt_kind_e         kind,
    input  logic [IDW-1:0]    dest_id,
    input  logic [CHW-1:0]    pkt_chan,
    input  logic              in_phase,
    input  logic [NSPACE-1:0] space_hit,
    input  logic              phy_en,
    input  logic              selfid_en,
    input  logic              bcast_en,
    input  logic              all_en,
    input  logic [NSPACE-1:0] space_en,
    input  logic              iso_mode,
    input  logic [CHW-1:0]    chan,
    output logic              accept
);

    logic async_ok;

    // Asynchronous rule: broadcast, receive-all or any enabled space
    assign async_ok = (bcast_en && (dest_id == '1)) || all_en
                    || ((space_en & space_hit) != '0);

    // Select the rule by packet class and buffer mode
    always_comb begin
        unique case (kind)
            PK_PHY:    accept = phy_en;
            PK_SELFID: accept = selfid_en && in_phase;
            PK_ASYNC:  accept = !iso_mode && async_ok;
            PK_ISO:    accept = iso_mode && (chan == pkt_chan);
            default:   accept = 1'b0;
        endcase
    end

endmodule

// File: rtl/rx_accept_filter.sv
// Module: top of the receive acceptance filter.
// It holds NBUF configuration slots, classifies the header offset once,
// evaluates each buffer's rule and registers the accept vector.
// Assumes buffer 0 is the debug buffer and that headers arrive as
// single-cycle strobes.
module rx_accept_filter
    import rxf_pkg::*;
#(
    parameter int NBUF      = 8,
    parameter int AW        = 12,
    parameter int DW        = 32,
    parameter int IDW       = 10,
    parameter int OFFW      = 48,
    parameter int CHW       = 6,
    parameter int BASE_ADDR = 'h354,
    parameter int STRIDE    = 'h14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [DW-1:0]   cfg_wdata,
    output logic [DW-1:0]   cfg_rdata,
    input  logic            hdr_valid,
    input  logic [1:0]      hdr_kind,
    input  logic [IDW-1:0]  hdr_dest_id,
    input  logic [OFFW-1:0] hdr_offset,
    input  logic [CHW-1:0]  hdr_channel,
    input  logic            selfid_phase,
    output logic            acc_valid,
    output logic [NBUF-1:0] acc_vec
);

    localparam logic [DW-1:0] DBG_RST   = DW'(32'h780);
    localparam logic [DW-1:0] OTHER_RST = DW'(32'h080);

    pkt_kind_e         kind;
    logic [NSPACE-1:0] space_hit;
    logic [DW-1:0]     rd_each [NBUF];
    logic [NBUF-1:0]   match_v;
    logic [NBUF-1:0]   phy_en_v;
    logic [NBUF-1:0]   iso_v;

    assign kind = pkt_kind_e'(hdr_kind);

    rxf_space_decode u_space (
        .offset (hdr_offset),
        .hit    (space_hit)
    );

    for (genvar i = 0; i < NBUF; i++) begin : g_buf
        logic              selfid_en, bcast_en, all_en;
        logic [NSPACE-1:0] space_en;
        logic [CHW-1:0]    chan;

        rxf_cfg_slot #(
            .AW     (AW),
            .DW     (DW),
            .CHW    (CHW),
            .A_ADDR (BASE_ADDR + STRIDE * i),
            .B_ADDR (BASE_ADDR + STRIDE * i + 4),
            .A_RST  ((i == 0) ? DBG_RST : OTHER_RST)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .we        (cfg_we),
            .addr      (cfg_addr),
            .wdata     (cfg_wdata),
            .rdata     (rd_each[i]),
            .phy_en    (phy_en_v[i]),
            .selfid_en (selfid_en),
            .bcast_en  (bcast_en),
            .all_en    (all_en),
            .space_en  (space_en),
            .iso_mode  (iso_v[i]),
            .chan      (chan)
        );

        rxf_buf_match #(
            .IDW (IDW),
            .CHW (CHW)
        ) u_match (
            .kind      (kind),
            .dest_id   (hdr_dest_id),
            .pkt_chan  (hdr_channel),
            .in_phase  (selfid_phase),
            .space_hit (space_hit),
            .phy_en    (phy_en_v[i]),
            .selfid_en (selfid_en),
            .bcast_en  (bcast_en),
            .all_en    (all_en),
            .space_en  (space_en),
            .iso_mode  (iso_v[i]),
            .chan      (chan),
            .accept    (match_v[i])
        );
    end

    // Merge slot read data; at most one slot decodes a given address
    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NBUF; i++) cfg_rdata = cfg_rdata | rd_each[i];
    end

    // Register the verdict one cycle after the header strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_valid <= 1'b0;
            acc_vec   <= '0;
        end else begin
            acc_valid <= hdr_valid;
            acc_vec   <= hdr_valid ? match_v : '0;
        end
    end

    // R9
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> acc_valid);
    // R9
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !acc_valid);
    // R9
    idle_vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (acc_vec == '0));
    // R3
    phy_only_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && kind == PK_PHY) |=> ((acc_vec & ~$past(phy_en_v)) == '0));
    // R4
    selfid_out_of_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && kind == PK_SELFID && !selfid_phase) |=> (acc_vec == '0));
    // R8
    iso_only_iso_bufs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && kind == PK_ISO) |=> ((acc_vec & ~$past(iso_v)) == '0));
    // R8
    async_skips_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && kind == PK_ASYNC) |=> ((acc_vec & $past(iso_v)) == '0));

endmodule

// File: tb/tb_rx_accept_filter.sv
// Scoreboard bench: a driver task computes the expected accept vector from
// a shadow copy of the configuration and queues it; a monitor pops the
// queue on each acc_valid and compares.
module tb_rx_accept_filter;

    localparam int NBUF = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [11:0] cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        hdr_valid;
    logic [1:0]  hdr_kind;
    logic [9:0]  hdr_dest_id;
    logic [47:0] hdr_offset;
    logic [5:0]  hdr_channel;
    logic        selfid_phase;
    logic        acc_valid;
    logic [7:0]  acc_vec;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] sh_a [NBUF];
    logic [31:0] sh_b [NBUF];
    logic [7:0]  exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;   // 125 MHz

    rx_accept_filter dut (
        .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
        .hdr_valid, .hdr_kind, .hdr_dest_id, .hdr_offset, .hdr_channel,
        .selfid_phase, .acc_valid, .acc_vec
    );

    function automatic void check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endfunction

    function automatic logic [47:0] lim(input int unsigned dummy);
        return 48'h0;
    endfunction

    // Expected verdict from the requirement text (R3..R8)
    function automatic logic [7:0] model(logic [1:0] k, logic [9:0] d,
                                         logic [47:0] o, logic [5:0] ch, logic ph);
        logic [7:0] v;
        logic [4:0] sp;
        sp[4] = (o <= 48'h7FFF_FFFF_FFFF);
        sp[3] = (o >= 48'h8000_0000_0000) && (o <= 48'hFFFF_DFFF_FFFF);
        sp[2] = (o >= 48'hFFFF_E000_0000) && (o <= 48'hFFFF_EFFF_FFFF);
        sp[1] = (o >= 48'hFFFF_F000_0000) && (o <= 48'hFFFF_F000_01FF);
        sp[0] = (o >= 48'hFFFF_F000_0200) && (o <= 48'hFFFF_F000_03FF);
        for (int i = 0; i < NBUF; i++) begin
            case (k)
                2'd0: v[i] = sh_a[i][10];
                2'd1: v[i] = sh_a[i][9] && ph;
                2'd2: v[i] = !sh_b[i][8] && ((sh_a[i][8] && d == 10'h3FF) ||
                             sh_a[i][7] || ((sh_a[i][6:2] & sp) != 0));
                default: v[i] = sh_b[i][8] && (sh_b[i][5:0] == ch);
            endcase
        end
        return v;
    endfunction

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        for (int i = 0; i < NBUF; i++) begin
            if (a == 12'(12'h354 + 12'h14 * i)) sh_a[i] = d & 32'h7FC;
            if (a == 12'(12'h358 + 12'h14 * i)) sh_b[i] = d & 32'h13F;
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(string req, logic [11:0] a, logic [31:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1 check(req, cfg_rdata, exp);
    endtask

    // Drive one header at a negedge and queue its expected verdict
    task automatic send(string req, logic [1:0] k, logic [9:0] d,
                        logic [47:0] o, logic [5:0] ch, logic ph);
        @(negedge clk);
        hdr_valid = 1'b1; hdr_kind = k; hdr_dest_id = d;
        hdr_offset = o; hdr_channel = ch; selfid_phase = ph;
        exp_q.push_back(model(k, d, o, ch, ph));
        tag_q.push_back(req);
    endtask

    task automatic idle();
        @(negedge clk);
        hdr_valid = 1'b0;
    endtask

    // Monitor: compare each valid verdict with the head of the queue
    always @(negedge clk) begin
        if (rst_n === 1'b1 && acc_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected acc_valid", 32'(acc_valid), 32'd0);
            end else begin
                check(tag_q.pop_front(), 32'(acc_vec), 32'(exp_q.pop_front()));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        hdr_valid = 1'b0; hdr_kind = '0; hdr_dest_id = '0;
        hdr_offset = '0; hdr_channel = '0; selfid_phase = 1'b0;
        for (int i = 0; i < NBUF; i++) begin
            sh_a[i] = (i == 0) ? 32'h780 : 32'h080;
            sh_b[i] = 32'h0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        for (int i = 0; i < NBUF; i++) begin
            rd("R1 filter reset", 12'(12'h354 + 12'h14 * i), sh_a[i]);
            rd("R1 stream reset", 12'(12'h358 + 12'h14 * i), 32'h0);
        end
        check("R9 idle after reset", {31'd0, acc_valid}, 32'd0);

        // Default traffic: debug buffer takes PHY/self-ID, all take async
        send("R3 PHY default", 2'd0, 10'h001, 48'h0, 6'd0, 1'b0);
        send("R4 self-ID in phase", 2'd1, 10'h001, 48'h0, 6'd0, 1'b1);
        send("R4 self-ID outside phase", 2'd1, 10'h001, 48'h0, 6'd0, 1'b0);
        send("R6 async receive-all", 2'd2, 10'h005, 48'hFFFF_FFFF_FFFF, 6'd0, 1'b0);
        idle();
        @(negedge clk);
        check("R9 vector zero when idle", 32'(acc_vec), 32'd0);

        // R2 reserved bits and unmapped addresses
        wr(12'h368, 32'hFFFF_FFFF);
        rd("R2 filter reserved bits", 12'h368, 32'h7FC);
        wr(12'h36C, 32'hFFFF_FFFF);
        rd("R2 stream reserved bits", 12'h36C, 32'h13F);
        wr(12'h350, 32'hFFFF_FFFF);
        rd("R2 unmapped reads zero", 12'h350, 32'h0);
        rd("R2 unmapped write ignored", 12'h354, 32'h780);
        wr(12'h36C, 32'h0);

        // Per-space buffers; buf6 broadcast+CSR+serial-bus; buf7 isochronous
        wr(12'h368, 32'h040);
        wr(12'h37C, 32'h020);
        wr(12'h390, 32'h010);
        wr(12'h3A4, 32'h008);
        wr(12'h3B8, 32'h004);
        wr(12'h3CC, 32'h10C);
        wr(12'h3E0, 32'h0FC);
        wr(12'h3E4, 32'h105);
        wr(12'h354, 32'h600);   // debug: PHY + self-ID, no async
        rd("R8 stream word readback", 12'h3E4, 32'h105);

        // R3 after changes; R7 space edges
        send("R3 PHY reprogrammed", 2'd0, 10'h000, 48'h0, 6'd0, 1'b0);
        send("R7 offset zero", 2'd2, 10'h001, 48'h0, 6'd0, 1'b0);
        send("R7 lower-half top", 2'd2, 10'h001, 48'h7FFF_FFFF_FFFF, 6'd0, 1'b0);
        send("R7 upper-half base", 2'd2, 10'h001, 48'h8000_0000_0000, 6'd0, 1'b0);
        send("R7 upper-half top", 2'd2, 10'h001, 48'hFFFF_DFFF_FFFF, 6'd0, 1'b0);
        send("R7 private base", 2'd2, 10'h001, 48'hFFFF_E000_0000, 6'd0, 1'b0);
        send("R7 private top", 2'd2, 10'h001, 48'hFFFF_EFFF_FFFF, 6'd0, 1'b0);
        send("R7 CSR base", 2'd2, 10'h001, 48'hFFFF_F000_0000, 6'd0, 1'b0);
        send("R7 CSR top", 2'd2, 10'h001, 48'hFFFF_F000_01FF, 6'd0, 1'b0);
        send("R7 serial-bus base", 2'd2, 10'h001, 48'hFFFF_F000_0200, 6'd0, 1'b0);
        send("R7 serial-bus top", 2'd2, 10'h001, 48'hFFFF_F000_03FF, 6'd0, 1'b0);
        send("R7 above all spaces", 2'd2, 10'h001, 48'hFFFF_F000_0400, 6'd0, 1'b0);
        send("R5 broadcast unmapped offset", 2'd2, 10'h3FF, 48'hFFFF_F000_0400, 6'd0, 1'b0);
        send("R5 near-broadcast ID", 2'd2, 10'h3FE, 48'hFFFF_F000_0400, 6'd0, 1'b0);
        idle();

        // R8 isochronous mode
        send("R8 iso channel match", 2'd3, 10'h000, 48'h0, 6'd5, 1'b0);
        send("R8 iso channel mismatch", 2'd3, 10'h000, 48'h0, 6'd6, 1'b0);
        send("R8 async to iso buffer", 2'd2, 10'h3FF, 48'h0, 6'd5, 1'b0);
        idle();

        // R6 receive-all with no spaces; R4 with self-ID widened
        wr(12'h37C, 32'h080);
        wr(12'h390, 32'h200);
        send("R6 receive-all no spaces", 2'd2, 10'h010, 48'hFFFF_F000_0800, 6'd0, 1'b0);
        send("R4 two self-ID buffers", 2'd1, 10'h000, 48'h0, 6'd0, 1'b1);
        idle();

        repeat (3) @(negedge clk);
        check("R9 all verdicts delivered", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule